// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a three-wire serial slave that owns a small bank of configuration registers for a clock-synthesis datapath. A host drives a serial clock, an active-low select and a data line; the block samples all three with its own system clock through two-flop synchronizers and acts on each detected rising edge of the serial clock. While select is low, every rising edge shifts one bit into a 15-bit frame register. A rising edge seen while select is high ends the frame: a write frame updates the addressed register, and a read frame copies the addressed register back into the frame register and turns the data pin around.

A read therefore spans two framed cycles. The first carries the request. In the second, the block drives the address and then the register data onto its data output, one bit per rising edge, while the host ignores what it shifts in. Any single register can be rewritten on its own. All register contents are presented continuously as one flat parallel output for the datapath. The pad itself is outside the block, which supplies the output value and a tri-state enable.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset the registers hold reg0=0x04F, reg1=0x003, reg2=0x006, reg3=0x013, reg4=0x7DC (low three bits 4, next three bits 3, bits 6..10 all ones), reg5=0x5C1, reg6=0x047, and reg i appears on `cfg_flat[11*i +: 11]`.
- R2: While select is low, each rising serial clock edge shifts one data bit; bit 0 of a frame is the direction (1 read, 0 write), bits 1..3 the address least significant bit first, bits 4..14 the data least significant bit first.
- R3: A rising serial clock edge with select high commits a write frame: the 11 data bits go to the addressed register, and the data line level on that edge has no effect.
- R4: A write to one register leaves every other register unchanged.
- R5: A read frame, on its commit edge, asserts `ser_oe`; in the next select-low cycle `ser_dout` shows address bit 0 before the first rising edge and advances one bit per rising edge: three address bits, then eleven data bits, each least significant first.
- R6: The commit edge that ends a read-out cycle writes nothing; `ser_oe` stays high until select next goes low, then drops.
- R7: Addresses 7 and above change no register on write and return zero data on read.
- R8: Register outputs change only on a commit edge, never while a frame is being shifted.
- R9: `ser_oe` is low after reset and whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Data line as seen at the pad input |
| ser_dout | output | 1 | Read data to drive onto the pad |
| ser_oe | output | 1 | Tri-state enable for the data pad |
| cfg_flat | output | 77 | All registers, register i at bits 11*i+10..11*i |

## Verification
On every cycle the assertions check that the frame register only moves on a detected serial edge, that the register outputs only move on a commit edge and never on the edge closing a read-out, and that the pad enable rises only after a read request commits and falls only after select drops. The bench's scenarios are needed to show the bit order of frames, the default values, the address decoding for all eight codes including the unused one, and the exact read-out sequence, which it does by writing, reading back and walking a single one through every data bit.

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int NREG = 7,
  parameter int DW   = 11,
  parameter int AW   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_sel_n,
  input  logic               ser_din,
  output logic               ser_dout,
  output logic               ser_oe,
  output logic [NREG*DW-1:0] cfg_flat
);
  localparam int FW = 1 + AW + DW;

  function automatic logic [DW-1:0] reset_val(int idx);
    case (idx)
      0: return DW'(11'h04F);
      1: return DW'(11'h003);
      2: return DW'(11'h006);
      3: return DW'(11'h013);
      4: return DW'(11'h7DC);
      5: return DW'(11'h5C1);
      6: return DW'(11'h047);
      default: return '0;
    endcase
  endfunction

  logic [2:0] sclk_p, sel_p;
  logic [1:0] din_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0;
      sel_p  <= '1;
      din_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], ser_clk};
      sel_p  <= {sel_p[1:0], ser_sel_n};
      din_p  <= {din_p[0], ser_din};
    end

  wire sclk_rise = sclk_p[1] & ~sclk_p[2];
  wire sel_hi    = sel_p[1];
  wire sel_fall  = sel_p[2] & ~sel_p[1];
  wire commit    = sclk_rise & sel_hi;
  wire shift_en  = sclk_rise & ~sel_hi;

  logic [FW-1:0] sr;
  logic          rd_mode;
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] rd_word;

  wire          fr_dir  = sr[0];
  wire [AW-1:0] fr_addr = sr[AW:1];
  wire [DW-1:0] fr_data = sr[FW-1:AW+1];
  wire          do_wr   = commit & ~rd_mode & ~fr_dir;
  wire          do_rd   = commit & ~rd_mode & fr_dir;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++)
      if (fr_addr == AW'(i)) rd_word = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sr <= '0;
    else if (shift_en) sr <= {din_p[1], sr[FW-1:1]};
    else if (do_rd)    sr <= {1'b0, rd_word, fr_addr};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      rd_mode <= 1'b0;
    else if (commit) rd_mode <= ~rd_mode & fr_dir;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    ser_oe <= 1'b0;
    else if (do_rd)                ser_oe <= 1'b1;
    else if (sel_fall && !rd_mode) ser_oe <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    for (int i = 0; i < NREG; i++)
      if (!rst_n)                             regs[i] <= reset_val(i);
      else if (do_wr && fr_addr == AW'(i))    regs[i] <= fr_data;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign cfg_flat[g*DW +: DW] = regs[g];
  end

  assign ser_dout = sr[0];

  // R2
  shift_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(sr));

  // R8
  cfg_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cfg_flat));

  // R6
  readout_end_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rd_mode) |=> $stable(cfg_flat));

  // R5
  oe_rise_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_oe) |-> $past(commit && fr_dir));

  // R9
  oe_fall_on_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_oe) |-> $past(sel_fall));
endmodule

// File: tb/cfg_serial_port_bench.sv
module cfg_serial_port_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        sclk = 0, sel_n = 1, din = 0;
  logic        dout, oe;
  logic [76:0] cfg;
  int          nvec = 0, nbad = 0;
  bit          done = 0;
  logic [10:0] mdl [7];

  always #4 clk = ~clk;

  cfg_serial_port u_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_sel_n(sel_n),
    .ser_din(din), .ser_dout(dout), .ser_oe(oe), .cfg_flat(cfg));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (10) @(negedge clk);
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < 7; i++) chk(tag, 32'(cfg[i*11 +: 11]), 32'(mdl[i]));
  endtask

  task automatic xfer(input bit dir, input logic [2:0] a, input logic [10:0] d,
                      output logic [13:0] got);
    logic [14:0] f;
    f = {d, a, dir};
    got = '0;
    sel_n = 0;
    for (int i = 0; i < 15; i++) begin
      din = f[i];
      half();
      if (i < 14) got[i] = dout;
      if (i == 8) check_regs("R8 mid-frame");
      sclk = 1; half(); sclk = 0;
    end
    din = 1;  // R3: line level on commit edge must not matter
    half();
    sel_n = 1; half();
    sclk = 1; half(); sclk = 0; half();
    din = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [10:0] v);
    logic [13:0] g;
    xfer(0, a, v, g);
    if (a < 7) mdl[a] = v;
    check_regs("R3/R4/R7 write");
    chk("R9 oe idle after write", 32'(oe), 0);
  endtask

  task automatic rd(input logic [2:0] a);
    logic [13:0] g;
    logic [10:0] e;
    xfer(1, a, 11'h7FF, g);
    chk("R5 oe after read request", 32'(oe), 1);
    xfer(0, 3'd0, 11'd0, g);
    e = (a < 7) ? mdl[a] : 11'd0;
    chk("R5/R7 read-out bits", 32'(g), 32'({e, a}));
    check_regs("R6 no write at read-out end");
    chk("R6 oe held until select low", 32'(oe), 1);
    sel_n = 0; half();
    chk("R6 oe released on select low", 32'(oe), 0);
    sel_n = 1; half();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    mdl[0] = 11'h04F; mdl[1] = 11'h003; mdl[2] = 11'h006; mdl[3] = 11'h013;
    mdl[4] = 11'h7DC; mdl[5] = 11'h5C1; mdl[6] = 11'h047;
    repeat (5) @(negedge clk);
    rst_n = 1;
    half();
    check_regs("R1 defaults");
    chk("R9 oe after reset", 32'(oe), 0);

    for (int a = 0; a < 8; a++) rd(3'(a));
    for (int a = 0; a < 8; a++) wr(3'(a), 11'((a * 613 + 'h2B3) & 'h7FF));
    for (int a = 7; a >= 0; a--) rd(3'(a));

    for (int b = 0; b < 11; b++) begin  // R2 bit ordering
      wr(3'd2, 11'(1 << b));
      rd(3'd2);
    end
    wr(3'd5, 11'h555);
    wr(3'd6, 11'h2AA);
    rd(3'd5);
    rd(3'd6);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule